// File: doc/BRIEF.md
# Capture/Compare Timer Unit

This block pairs one 16-bit up-counting timer with a small bank of 16-bit channel registers. The timer advances on one of three sources: the system clock divided by a programmable power of two, rising edges on an external count pin, or single-cycle pulses on an event input, typically another timer's overflow. When the counter passes its all-ones value, it loads a reload value instead of wrapping to zero and raises its own interrupt flag.

Each channel is either a capture channel or a compare channel. A capture channel latches the timer value when its synchronized input pin shows the selected transition. A compare channel can work in one of four modes. It can raise a flag on every match or on only one match per timer period, and it can either toggle its output pin, or set the pin on a match and clear it on overflow, which gives a PWM waveform. Software uses a single-cycle write strobe and a combinational read port.

Top module: `capcom_unit`

## Requirements
- R1: With control word bit 0 (run) set and bits [5:4] (source) equal to 0, the timer advances by one every 2^(sel+3) clock cycles, where sel is control bits [3:1]. The control word is at address 0.
- R2: With source 1, each rising edge on `cnt_pin`, after a two-stage synchronizer, advances the timer by one. With source 2, each cycle in which `cnt_evt` is high advances it by one.
- R3: An advance from 16'hFFFF loads the reload register (address 2) into the timer (address 1) and sets flag bit 0, which drives `tmr_irq`.
- R4: Compare mode 0 (channel config function 3'b100) sets the channel flag on every match, including several matches in one timer period, and leaves the channel pin unchanged. A match means that the value the timer advances to equals the channel register. The channel register for channel i is at address 4+i and its config at 4+CH_N+i. Config bits [2:0] hold the function and bits [4:3] the capture edges. Channel i's flag is bit i+1 of the flag register (address 3) and drives `ch_irq[i]`.
- R5: Compare mode 1 (function 3'b101) toggles the channel pin on every match and sets the flag.
- R6: Compare mode 2 (function 3'b110) sets the flag on the first match of a timer period only. Later matches before the next overflow are ignored. Writing the channel config re-arms the channel.
- R7: Compare mode 3 (function 3'b111) sets the pin to 1 and the flag on the first match of a period, and clears the pin on timer overflow. A match in the same cycle as an overflow counts in the new period.
- R8: Capture (function 3'b001) stores the current timer value into the channel register and sets the flag on a synchronized input transition. Config bit 3 enables rising edges and bit 4 enables falling edges. A transition that is not enabled changes nothing.
- R9: Writing the flag register clears each flag whose data bit is 1. Bits written as 0 keep their flags. A hardware set in the same cycle wins over the clear.
- R10: After reset, every register reads zero, and all pins and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | TW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | TW | Read data, combinational |
| cnt_pin | input | 1 | External count pin, asynchronous |
| cnt_evt | input | 1 | Synchronous count event pulse |
| cap_pin | input | CH_N | Capture inputs, asynchronous |
| cmp_pin | output | CH_N | Compare output pins |
| tmr_irq | output | 1 | Timer overflow flag |
| ch_irq | output | CH_N | Channel event flags |

## Verification
On every cycle the assertions check four things: that an overflow loads the reload value and raises the timer flag, that capture events latch the pre-edge timer value, that mode-1 events toggle the pin while modes 0 and 2 never move it, and that mode 3 clears its pin on overflow. A per-channel counter in the checker also confirms that the once-per-period modes never fire twice between overflows. Only the bench scenarios can show the prescaler rate for each divider setting, the counting of synchronized pin edges, a channel re-arming across a wrap, the edge selection of capture, and the write-one-to-clear flag behaviour.

// File: rtl/capcom_pkg.sv
`timescale 1ns/1ps
package capcom_pkg;

    localparam int PS_MIN   = 3;
    localparam int PS_SEL_W = 3;

    typedef enum logic [2:0] {
        FN_OFF  = 3'b000,
        FN_CAPT = 3'b001,
        FN_CMP0 = 3'b100,
        FN_CMP1 = 3'b101,
        FN_CMP2 = 3'b110,
        FN_CMP3 = 3'b111
    } ch_func_e;

    typedef enum logic [1:0] {
        SRC_PRESC = 2'd0,
        SRC_PIN   = 2'd1,
        SRC_EVT   = 2'd2,
        SRC_NONE  = 2'd3
    } cnt_src_e;

    typedef struct packed {
        logic [1:0] edge_sel;
        ch_func_e   func;
    } ch_cfg_t;

    typedef struct packed {
        cnt_src_e              src;
        logic [PS_SEL_W-1:0]   ps_sel;
        logic                  run;
    } tmr_ctrl_t;

    localparam int CFG_W  = $bits(ch_cfg_t);
    localparam int CTRL_W = $bits(tmr_ctrl_t);

    localparam int A_CTRL   = 0;
    localparam int A_TMR    = 1;
    localparam int A_RELOAD = 2;
    localparam int A_FLAGS  = 3;
    localparam int A_VAL0   = 4;

    function automatic logic is_cmp(input logic [2:0] f);
        return f[2];
    endfunction

    function automatic logic is_once(input logic [2:0] f);
        return f[2] & f[1];
    endfunction

endpackage

// File: rtl/capcom_tick_gen.sv
`timescale 1ns/1ps
module capcom_tick_gen
    import capcom_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tmr_ctrl_t ctrl,
    input  logic      cnt_pin,
    input  logic      cnt_evt,
    output logic      tick
);
    localparam int PCW = PS_MIN + (1 << PS_SEL_W) - 1;
    localparam logic [PCW:0] ONE_W = 1;

    logic [PCW-1:0] pre_cnt;
    logic [PCW-1:0] pre_lim;
    logic [PCW:0]   lim_w;
    logic           presc_on;
    logic           pre_hit;
    logic [2:0]     pin_sync;
    logic           pin_rise;

    always_comb begin
        int sh;
        sh      = int'(ctrl.ps_sel) + PS_MIN;
        lim_w   = (ONE_W << sh) - ONE_W;
        pre_lim = lim_w[PCW-1:0];
    end

    assign presc_on = ctrl.run && (ctrl.src == SRC_PRESC);
    assign pre_hit  = presc_on && (pre_cnt == pre_lim);
    assign pin_rise = pin_sync[1] & ~pin_sync[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt  <= '0;
            pin_sync <= '0;
        end else begin
            pin_sync <= {pin_sync[1:0], cnt_pin};
            if (!presc_on || pre_hit) pre_cnt <= '0;
            else                      pre_cnt <= pre_cnt + 1'b1;
        end
    end

    always_comb begin
        tick = 1'b0;
        if (ctrl.run) begin
            unique case (ctrl.src)
                SRC_PRESC: tick = pre_hit;
                SRC_PIN:   tick = pin_rise;
                SRC_EVT:   tick = cnt_evt;
                default:   tick = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/capcom_timer.sv
`timescale 1ns/1ps
module capcom_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          ld_en,
    input  logic [TW-1:0] ld_val,
    input  logic [TW-1:0] reload,
    output logic [TW-1:0] tmr,
    output logic [TW-1:0] tmr_nxt,
    output logic          wrap
);
    logic at_top;

    assign at_top  = &tmr;
    assign tmr_nxt = at_top ? reload : tmr + TW'(1);
    assign wrap    = adv & at_top;

    always_ff @(posedge clk) begin
        if (rst)        tmr <= '0;
        else if (ld_en) tmr <= ld_val;
        else if (adv)   tmr <= tmr_nxt;
    end

endmodule

// File: rtl/capcom_channel.sv
`timescale 1ns/1ps
module capcom_channel
    import capcom_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          val_we,
    input  logic [TW-1:0] wr_data,
    input  logic          adv,
    input  logic          wrap,
    input  logic [TW-1:0] tmr,
    input  logic [TW-1:0] tmr_nxt,
    input  logic          cap_pin,
    output ch_cfg_t       cfg,
    output logic [TW-1:0] val,
    output logic          pin,
    output logic          evt
);
    logic [2:0] cap_sync;
    logic       rise, fall, cap_hit;
    logic       armed, match, fire;

    assign rise    = cap_sync[1] & ~cap_sync[2];
    assign fall    = ~cap_sync[1] & cap_sync[2];
    assign cap_hit = (cfg.func == FN_CAPT) &&
                     ((cfg.edge_sel[0] && rise) || (cfg.edge_sel[1] && fall));

    assign match = is_cmp(cfg.func) && adv && (tmr_nxt == val);
    assign fire  = match && (!is_once(cfg.func) || armed || wrap);
    assign evt   = fire | cap_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_sync <= '0;
            cfg      <= '0;
            val      <= '0;
            pin      <= 1'b0;
            armed    <= 1'b1;
        end else begin
            cap_sync <= {cap_sync[1:0], cap_pin};
            if (cfg_we) cfg <= ch_cfg_t'(wr_data[CFG_W-1:0]);

            if (cap_hit)     val <= tmr;
            else if (val_we) val <= wr_data;

            if (cfg_we)                          armed <= 1'b1;
            else if (fire && is_once(cfg.func))  armed <= 1'b0;
            else if (wrap)                       armed <= 1'b1;

            if (fire && cfg.func == FN_CMP1)      pin <= ~pin;
            else if (fire && cfg.func == FN_CMP3) pin <= 1'b1;
            else if (wrap && cfg.func == FN_CMP3) pin <= 1'b0;
        end
    end

endmodule

// File: rtl/capcom_unit.sv
`timescale 1ns/1ps
module capcom_unit
    import capcom_pkg::*;
#(
    parameter int CH_N = 4,
    parameter int TW   = 16,
    localparam int AW  = $clog2(A_VAL0 + 2 * CH_N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [TW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [TW-1:0]   rd_data,
    input  logic            cnt_pin,
    input  logic            cnt_evt,
    input  logic [CH_N-1:0] cap_pin,
    output logic [CH_N-1:0] cmp_pin,
    output logic            tmr_irq,
    output logic [CH_N-1:0] ch_irq
);
    localparam int CFG_BASE = A_VAL0 + CH_N;

    tmr_ctrl_t                   ctrl_q;
    logic [TW-1:0]               reload_q;
    logic [CH_N:0]               flag_q;
    logic                        we_ctrl, we_tmr, we_rel, we_flag;
    logic                        tick, adv, wrap;
    logic [TW-1:0]               tmr, tmr_nxt;
    logic [CH_N-1:0]             ch_evt, ch_pin, cfg_we, val_we;
    logic [CH_N-1:0][TW-1:0]     ch_val;
    logic [CH_N-1:0][2:0]        ch_func;
    ch_cfg_t                     ch_cfg [CH_N];
    logic [CH_N:0]               flag_clr;

    assign we_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
    assign we_tmr  = wr_en && (wr_addr == AW'(A_TMR));
    assign we_rel  = wr_en && (wr_addr == AW'(A_RELOAD));
    assign we_flag = wr_en && (wr_addr == AW'(A_FLAGS));
    assign adv     = tick && !we_tmr;

    capcom_tick_gen u_tick (
        .clk(clk), .rst(rst), .ctrl(ctrl_q),
        .cnt_pin(cnt_pin), .cnt_evt(cnt_evt), .tick(tick)
    );

    capcom_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .adv(adv), .ld_en(we_tmr), .ld_val(wr_data),
        .reload(reload_q), .tmr(tmr), .tmr_nxt(tmr_nxt), .wrap(wrap)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        assign cfg_we[i]  = wr_en && (wr_addr == AW'(CFG_BASE + i));
        assign val_we[i]  = wr_en && (wr_addr == AW'(A_VAL0 + i));
        assign ch_func[i] = ch_cfg[i].func;

        capcom_channel #(.TW(TW)) u_ch (
            .clk(clk), .rst(rst), .cfg_we(cfg_we[i]), .val_we(val_we[i]),
            .wr_data(wr_data), .adv(adv), .wrap(wrap), .tmr(tmr),
            .tmr_nxt(tmr_nxt), .cap_pin(cap_pin[i]), .cfg(ch_cfg[i]),
            .val(ch_val[i]), .pin(ch_pin[i]), .evt(ch_evt[i])
        );
    end

    assign flag_clr = we_flag ? wr_data[CH_N:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            flag_q   <= '0;
        end else begin
            if (we_ctrl) ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
            if (we_rel)  reload_q <= wr_data;
            flag_q <= (flag_q & ~flag_clr) | {ch_evt, wrap};
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_CTRL))   rd_data = TW'(ctrl_q);
        if (rd_addr == AW'(A_TMR))    rd_data = tmr;
        if (rd_addr == AW'(A_RELOAD)) rd_data = reload_q;
        if (rd_addr == AW'(A_FLAGS))  rd_data = TW'(flag_q);
        for (int i = 0; i < CH_N; i++) begin
            if (rd_addr == AW'(A_VAL0 + i))   rd_data = ch_val[i];
            if (rd_addr == AW'(CFG_BASE + i)) rd_data = TW'(ch_cfg[i]);
        end
    end

    assign cmp_pin = ch_pin;
    assign tmr_irq = flag_q[0];
    assign ch_irq  = flag_q[CH_N:1];

endmodule

// File: rtl/capcom_chk.sv
`timescale 1ns/1ps
module capcom_chk
    import capcom_pkg::*;
#(
    parameter int CH_N = 4,
    parameter int TW   = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    adv,
    input logic                    wrap,
    input logic [TW-1:0]           tmr,
    input logic [TW-1:0]           reload_q,
    input logic                    tmr_irq,
    input logic [CH_N-1:0]         ch_evt,
    input logic [CH_N-1:0]         ch_pin,
    input logic [CH_N-1:0]         cfg_we,
    input logic [CH_N-1:0][2:0]    ch_func,
    input logic [CH_N-1:0][TW-1:0] ch_val
);
    // R3
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && (&tmr)) |=> (tmr == $past(reload_q)));

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && (&tmr)) |=> tmr_irq);

    for (genvar i = 0; i < CH_N; i++) begin : g_chk
        logic [1:0] per_cnt;

        always_ff @(posedge clk) begin
            if (rst) per_cnt <= '0;
            else if (wrap || cfg_we[i]) per_cnt <= {1'b0, ch_evt[i] && is_once(ch_func[i]) && !cfg_we[i]};
            else if (ch_evt[i] && is_once(ch_func[i]) && per_cnt != 2'd3) per_cnt <= per_cnt + 2'd1;
        end

        // R6
        once_per_period_chk: assert property (@(posedge clk) disable iff (rst)
            per_cnt <= 2'd1);

        // R5
        toggle_mode_chk: assert property (@(posedge clk) disable iff (rst)
            (ch_evt[i] && ch_func[i] == FN_CMP1) |=> (ch_pin[i] != $past(ch_pin[i])));

        // R4
        irq_only_pin_chk: assert property (@(posedge clk) disable iff (rst)
            (ch_func[i] == FN_CMP0 || ch_func[i] == FN_CMP2) |=> $stable(ch_pin[i]));

        // R7
        pwm_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (wrap && ch_func[i] == FN_CMP3 && !ch_evt[i]) |=> !ch_pin[i]);

        // R8
        capture_value_chk: assert property (@(posedge clk) disable iff (rst)
            (ch_evt[i] && ch_func[i] == FN_CAPT) |=> (ch_val[i] == $past(tmr)));
    end

endmodule

bind capcom_unit capcom_chk #(.CH_N(CH_N), .TW(TW)) u_chk (
    .clk(clk), .rst(rst), .adv(adv), .wrap(wrap), .tmr(tmr),
    .reload_q(reload_q), .tmr_irq(tmr_irq), .ch_evt(ch_evt),
    .ch_pin(ch_pin), .cfg_we(cfg_we), .ch_func(ch_func), .ch_val(ch_val)
);

// File: tb/test_capcom_unit.sv
`timescale 1ns/1ps
module test_capcom_unit;
    localparam int CH_N = 4;
    localparam int TW   = 16;
    localparam int AW   = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [TW-1:0]   wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [TW-1:0]   rd_data;
    logic            cnt_pin = 1'b0;
    logic            cnt_evt = 1'b0;
    logic [CH_N-1:0] cap_pin = '0;
    logic [CH_N-1:0] cmp_pin;
    logic            tmr_irq;
    logic [CH_N-1:0] ch_irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    capcom_unit #(.CH_N(CH_N), .TW(TW)) i_capcom_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_pin(cnt_pin), .cnt_evt(cnt_evt), .cap_pin(cap_pin),
        .cmp_pin(cmp_pin), .tmr_irq(tmr_irq), .ch_irq(ch_irq)
    );

    localparam int CTRL = 0, TMR = 1, REL = 2, FLG = 3, VAL = 4, CFG = 8;

    task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [TW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [TW-1:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        #1 v = rd_data;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cnt_evt = 1'b1;
            @(posedge clk); #1 cnt_evt = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [TW-1:0] v;
        for (int a = 0; a < 12; a++) begin
            rd(a, v);
            chk("R10 register after reset", v, '0);
        end
        chk("R10 pins after reset", TW'({cmp_pin, ch_irq, tmr_irq}), '0);
    endtask

    task automatic t_prescale;
        logic [TW-1:0] v;
        wr(CTRL, 16'h0000); wr(TMR, 16'h0000); wr(CTRL, 16'h0001);
        repeat (40) @(posedge clk);
        rd(TMR, v); chk("R1 divide by 8", v, 16'd5);
        wr(CTRL, 16'h0000); wr(TMR, 16'h0000); wr(CTRL, 16'h0003);
        repeat (48) @(posedge clk);
        rd(TMR, v); chk("R1 divide by 16", v, 16'd3);
    endtask

    task automatic t_ext;
        logic [TW-1:0] v;
        wr(CTRL, 16'h0000); wr(TMR, 16'h0000); wr(CTRL, 16'h0011);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) cnt_pin = 1'b1;
            repeat (3) @(negedge clk);
            cnt_pin = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(posedge clk);
        rd(TMR, v); chk("R2 pin edges counted", v, 16'd3);
        wr(CTRL, 16'h0021);
        pulses(4);
        rd(TMR, v); chk("R2 event pulses counted", v, 16'd7);
    endtask

    task automatic t_reload;
        logic [TW-1:0] v;
        wr(CTRL, 16'h0021); wr(FLG, 16'h001F);
        wr(REL, 16'hFFF0); wr(TMR, 16'hFFFE);
        pulses(1);
        rd(TMR, v); chk("R3 before wrap", v, 16'hFFFF);
        chk("R3 no flag before wrap", TW'(tmr_irq), 16'd0);
        pulses(1);
        rd(TMR, v); chk("R3 reload on wrap", v, 16'hFFF0);
        chk("R3 timer flag", TW'(tmr_irq), 16'd1);
        wr(FLG, 16'h0000);
        chk("R9 zero write keeps flag", TW'(tmr_irq), 16'd1);
        wr(FLG, 16'h0001);
        rd(FLG, v); chk("R9 write one clears", v, 16'h0000);
    endtask

    task automatic t_mode02;
        logic [TW-1:0] v;
        wr(TMR, 16'hFFF0); wr(VAL + 0, 16'hFFF3); wr(CFG + 0, 16'h0004);
        pulses(3);
        chk("R4 mode0 flag on match", TW'(ch_irq[0]), 16'd1);
        chk("R4 mode0 pin idle", TW'(cmp_pin[0]), 16'd0);
        wr(FLG, 16'h001F); wr(VAL + 0, 16'hFFF5);
        pulses(2);
        chk("R4 mode0 second match same period", TW'(ch_irq[0]), 16'd1);
        wr(CFG + 0, 16'h0006); wr(FLG, 16'h001F); wr(VAL + 0, 16'hFFF7);
        pulses(2);
        chk("R6 mode2 first match", TW'(ch_irq[0]), 16'd1);
        wr(FLG, 16'h001F); wr(VAL + 0, 16'hFFF9);
        pulses(2);
        chk("R6 mode2 second match ignored", TW'(ch_irq[0]), 16'd0);
        pulses(7);
        rd(TMR, v); chk("R3 wrap in mode2 run", v, 16'hFFF0);
        pulses(9);
        chk("R6 mode2 rearmed after wrap", TW'(ch_irq[0]), 16'd1);
        chk("R6 mode2 pin idle", TW'(cmp_pin[0]), 16'd0);
        wr(CFG + 0, 16'h0000);
    endtask

    task automatic t_mode1;
        wr(FLG, 16'h001F); wr(TMR, 16'hFFF0);
        wr(VAL + 2, 16'hFFF2); wr(CFG + 2, 16'h0005);
        pulses(2);
        chk("R5 first toggle", TW'(cmp_pin[2]), 16'd1);
        chk("R5 flag", TW'(ch_irq[2]), 16'd1);
        wr(VAL + 2, 16'hFFF4);
        pulses(2);
        chk("R5 second toggle", TW'(cmp_pin[2]), 16'd0);
        wr(CFG + 2, 16'h0000);
    endtask

    task automatic t_mode3;
        wr(FLG, 16'h001F); wr(TMR, 16'hFFF0);
        wr(VAL + 1, 16'hFFF2); wr(CFG + 1, 16'h0007);
        pulses(1);
        chk("R7 pin low before match", TW'(cmp_pin[1]), 16'd0);
        pulses(1);
        chk("R7 pin set on match", TW'(cmp_pin[1]), 16'd1);
        chk("R7 flag on match", TW'(ch_irq[1]), 16'd1);
        wr(FLG, 16'h001F); wr(VAL + 1, 16'hFFF4);
        pulses(2);
        chk("R7 second match no flag", TW'(ch_irq[1]), 16'd0);
        pulses(11);
        chk("R7 pin held to end of period", TW'(cmp_pin[1]), 16'd1);
        pulses(1);
        chk("R7 pin cleared on wrap", TW'(cmp_pin[1]), 16'd0);
        pulses(4);
        chk("R7 set again next period", TW'(cmp_pin[1]), 16'd1);
        wr(CFG + 1, 16'h0000);
    endtask

    task automatic t_capture;
        logic [TW-1:0] v;
        wr(CTRL, 16'h0021); wr(FLG, 16'h001F);
        wr(CFG + 3, 16'h0009); wr(TMR, 16'h1234);
        @(negedge clk) cap_pin[3] = 1'b1;
        repeat (4) @(posedge clk);
        rd(VAL + 3, v); chk("R8 rising capture value", v, 16'h1234);
        chk("R8 capture flag", TW'(ch_irq[3]), 16'd1);
        wr(FLG, 16'h001F); wr(TMR, 16'h2222);
        @(negedge clk) cap_pin[3] = 1'b0;
        repeat (4) @(posedge clk);
        rd(VAL + 3, v); chk("R8 falling ignored value", v, 16'h1234);
        chk("R8 falling ignored flag", TW'(ch_irq[3]), 16'd0);
        wr(CFG + 3, 16'h0019); wr(TMR, 16'h3333);
        @(negedge clk) cap_pin[3] = 1'b1;
        repeat (4) @(posedge clk);
        rd(VAL + 3, v); chk("R8 both edges rise", v, 16'h3333);
        wr(TMR, 16'h4444);
        @(negedge clk) cap_pin[3] = 1'b0;
        repeat (4) @(posedge clk);
        rd(VAL + 3, v); chk("R8 both edges fall", v, 16'h4444);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_prescale();
        t_ext();
        t_reload();
        t_mode02();
        t_mode1();
        t_mode3();
        t_capture();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule